// File: doc/BRIEF.md
# Real-Mode Effective Address Generator

This unit forms the memory operand address of a 16-bit real-mode instruction. It is given the two-bit mode field and the three-bit register/memory field of the addressing byte, the current contents of the four pointer registers (base B, base P, source index, destination index) and an optional displacement. It is also given an optional segment-override request and the four segment registers. From these it computes the 16-bit offset, picks a segment, forms the 20-bit physical address, and reports which registers the computation read.

The register-use mask lets a dependence tracker see every register that the address arithmetic consumed. That includes the segment register, which the instruction never names. The result is registered and appears one cycle after a valid request. Requests in register-direct mode (mode 3) produce no result.

Top module: `real_ea_unit`

## Requirements
- R1: With mode 0, r/m codes 0..7 give offsets base B + source index, base B + destination index, base P + source index, base P + destination index, source index, destination index, (direct, see R2) and base B, in that order.
- R2: Mode 0 with r/m 6 is a direct address: the offset equals the full 16-bit `disp`, and no pointer-register bit is set in `used_regs`.
- R3: Mode 1 adds `disp[7:0]`, sign-extended to 16 bits, to the register combination of R1; r/m 6 then uses base P alone.
- R4: Mode 2 adds the full 16-bit `disp` to the register combination of R1; r/m 6 then uses base P alone.
- R5: Offset arithmetic wraps modulo 2^16.
- R6: Without override, the segment is the stack segment (code 2) for r/m 2 and 3, and for r/m 6 in modes 1 and 2. It is the data segment (code 3) otherwise. Segment codes are 0 extra, 1 code, 2 stack, 3 data. `seg_base` holds the chosen segment register's value.
- R7: When `ovr_en` is 1, `ovr_seg` replaces the default segment.
- R8: `phys_addr` equals `seg_base`×16 + `ea_off`, truncated to 20 bits.
- R9: `used_regs` has bit 0 base B, bit 1 base P, bit 2 source index, bit 3 destination index, and bit 4+code for the chosen segment. Exactly one segment bit is set, plus the pointer registers actually added (at most two).
- R10: A request with `in_valid`=1 and mode other than 3 yields `out_valid`=1 exactly one clock later. Mode 3 requests, and idle cycles, give `out_valid`=0 in the next cycle.
- R11: After synchronous reset, `out_valid`, `ea_off`, `seg_sel`, `seg_base`, `phys_addr` and `used_regs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mod_f | input | 2 | Mode field of the addressing byte |
| rm_f | input | 3 | Register/memory field of the addressing byte |
| reg_bx | input | 16 | Base B register value |
| reg_bp | input | 16 | Base P register value |
| reg_si | input | 16 | Source index value |
| reg_di | input | 16 | Destination index value |
| disp | input | 16 | Displacement (low byte used in mode 1) |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| out_valid | output | 1 | Result strobe |
| ea_off | output | 16 | Effective offset |
| seg_sel | output | 2 | Chosen segment code |
| seg_base | output | 16 | Chosen segment value |
| phys_addr | output | 20 | Physical address |
| used_regs | output | 8 | Registers read by the computation |

## Verification
The bench builds the unit with its default parameters: 16-bit offsets and segments, a shift of 4, a 20-bit physical address and an 8-bit short displacement. With these widths, operand values near 0xFFFF are enough to reach the offset wrap and the 20-bit physical-address wrap. Negative short displacements exercise sign extension, and every r/m code is visited in each of the three memory modes, with and without overrides.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_e;

  typedef struct packed {
    logic use_bx;
    logic use_bp;
    logic use_si;
    logic use_di;
    logic disp_on;
    logic disp_wide;
    logic dflt_stack;
  } ea_dec_t;

  localparam int NUM_PTR = 4;
  localparam int NUM_SEG = 4;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [1:0] mod_f,
  input  logic [2:0] rm_f,
  output ea_dec_t    dec
);
  always_comb begin
    dec = '0;
    case (rm_f)
      3'd0: begin dec.use_bx = 1'b1; dec.use_si = 1'b1; end
      3'd1: begin dec.use_bx = 1'b1; dec.use_di = 1'b1; end
      3'd2: begin dec.use_bp = 1'b1; dec.use_si = 1'b1; dec.dflt_stack = 1'b1; end
      3'd3: begin dec.use_bp = 1'b1; dec.use_di = 1'b1; dec.dflt_stack = 1'b1; end
      3'd4: dec.use_si = 1'b1;
      3'd5: dec.use_di = 1'b1;
      3'd6: begin
        if (mod_f != 2'd0) begin
          dec.use_bp     = 1'b1;
          dec.dflt_stack = 1'b1;
        end
      end
      default: dec.use_bx = 1'b1;
    endcase
    case (mod_f)
      2'd0: begin dec.disp_on = (rm_f == 3'd6); dec.disp_wide = 1'b1; end
      2'd1: begin dec.disp_on = 1'b1; dec.disp_wide = 1'b0; end
      2'd2: begin dec.disp_on = 1'b1; dec.disp_wide = 1'b1; end
      default: begin dec.disp_on = 1'b0; dec.disp_wide = 1'b0; end
    endcase
  end

  // R2
  always_comb begin
    if (mod_f == 2'd0 && rm_f == 3'd6)
      direct_noreg_chk: assert ({dec.use_bx, dec.use_bp, dec.use_si, dec.use_di} == 4'b0
                                && dec.disp_on && dec.disp_wide);
  end
endmodule

// File: rtl/ea_offset.sv
module ea_offset
  import ea_pkg::*;
#(
  parameter int OFS_W        = 16,
  parameter int DISP_SHORT_W = 8
) (
  input  ea_dec_t          dec,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic [OFS_W-1:0] disp,
  output logic [OFS_W-1:0] offset
);
  localparam int EXT_W = OFS_W - DISP_SHORT_W;

  logic [OFS_W-1:0] disp_ext;
  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] index_term;

  always_comb begin
    if (!dec.disp_on)
      disp_ext = '0;
    else if (dec.disp_wide)
      disp_ext = disp;
    else
      disp_ext = {{EXT_W{disp[DISP_SHORT_W-1]}}, disp[DISP_SHORT_W-1:0]};
  end

  always_comb begin
    base_term  = (dec.use_bx ? reg_bx : '0) | (dec.use_bp ? reg_bp : '0);
    index_term = (dec.use_si ? reg_si : '0) | (dec.use_di ? reg_di : '0);
    offset     = base_term + index_term + disp_ext;
  end

  // R1
  always_comb begin
    if (!dec.disp_on)
      single_base_chk: assert (!(dec.use_bx && dec.use_bp) && !(dec.use_si && dec.use_di));
  end
endmodule

// File: rtl/ea_segment.sv
module ea_segment
  import ea_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = 20
) (
  input  logic             dflt_stack,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_seg,
  input  logic [SEG_W-1:0] seg_bank [NUM_SEG],
  input  logic [OFS_W-1:0] offset,
  output logic [1:0]       code,
  output logic [SEG_W-1:0] base,
  output logic [PHYS_W-1:0] phys
);
  localparam int SH_W = SEG_W + SEG_SHIFT;

  logic [SH_W-1:0] shifted;
  logic [SH_W-1:0] sum_c;

  always_comb begin
    if (ovr_en)
      code = ovr_seg;
    else if (dflt_stack)
      code = SEG_STACK;
    else
      code = SEG_DATA;
    base    = seg_bank[code];
    shifted = {base, {SEG_SHIFT{1'b0}}};
    sum_c   = shifted + {{(SH_W-OFS_W){1'b0}}, offset};
    phys    = sum_c[PHYS_W-1:0];
  end

  // R6
  always_comb begin
    if (!ovr_en)
      dflt_code_chk: assert (code == SEG_STACK || code == SEG_DATA);
  end
endmodule

// File: rtl/real_ea_unit.sv
module real_ea_unit
  import ea_pkg::*;
#(
  parameter int OFS_W        = 16,
  parameter int SEG_W        = 16,
  parameter int SEG_SHIFT    = 4,
  parameter int PHYS_W       = 20,
  parameter int DISP_SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mod_f,
  input  logic [2:0]        rm_f,
  input  logic [OFS_W-1:0]  reg_bx,
  input  logic [OFS_W-1:0]  reg_bp,
  input  logic [OFS_W-1:0]  reg_si,
  input  logic [OFS_W-1:0]  reg_di,
  input  logic [OFS_W-1:0]  disp,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_seg,
  input  logic [SEG_W-1:0]  seg_es,
  input  logic [SEG_W-1:0]  seg_cs,
  input  logic [SEG_W-1:0]  seg_ss,
  input  logic [SEG_W-1:0]  seg_ds,
  output logic              out_valid,
  output logic [OFS_W-1:0]  ea_off,
  output logic [1:0]        seg_sel,
  output logic [SEG_W-1:0]  seg_base,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [NUM_PTR+NUM_SEG-1:0] used_regs
);
  localparam int MASK_W = NUM_PTR + NUM_SEG;
  localparam int SH_W   = SEG_W + SEG_SHIFT;

  ea_dec_t           dec;
  logic [OFS_W-1:0]  off_c;
  logic [1:0]        code_c;
  logic [SEG_W-1:0]  base_c;
  logic [PHYS_W-1:0] phys_c;
  logic [SEG_W-1:0]  seg_bank [NUM_SEG];
  logic [MASK_W-1:0] mask_c;
  logic              fire;

  assign seg_bank[0] = seg_es;
  assign seg_bank[1] = seg_cs;
  assign seg_bank[2] = seg_ss;
  assign seg_bank[3] = seg_ds;
  assign fire = in_valid && (mod_f != 2'd3);

  ea_decode u_decode (
    .mod_f (mod_f),
    .rm_f  (rm_f),
    .dec   (dec)
  );

  ea_offset #(
    .OFS_W        (OFS_W),
    .DISP_SHORT_W (DISP_SHORT_W)
  ) u_offset (
    .dec    (dec),
    .reg_bx (reg_bx),
    .reg_bp (reg_bp),
    .reg_si (reg_si),
    .reg_di (reg_di),
    .disp   (disp),
    .offset (off_c)
  );

  ea_segment #(
    .OFS_W     (OFS_W),
    .SEG_W     (SEG_W),
    .SEG_SHIFT (SEG_SHIFT),
    .PHYS_W    (PHYS_W)
  ) u_segment (
    .dflt_stack (dec.dflt_stack),
    .ovr_en     (ovr_en),
    .ovr_seg    (ovr_seg),
    .seg_bank   (seg_bank),
    .offset     (off_c),
    .code       (code_c),
    .base       (base_c),
    .phys       (phys_c)
  );

  assign mask_c[0] = dec.use_bx;
  assign mask_c[1] = dec.use_bp;
  assign mask_c[2] = dec.use_si;
  assign mask_c[3] = dec.use_di;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_segbit
    assign mask_c[NUM_PTR+g] = (code_c == 2'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea_off    <= '0;
      seg_sel   <= '0;
      seg_base  <= '0;
      phys_addr <= '0;
      used_regs <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        ea_off    <= off_c;
        seg_sel   <= code_c;
        seg_base  <= base_c;
        phys_addr <= phys_c;
        used_regs <= mask_c;
      end
    end
  end

  // R10
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mod_f != 2'd3) |=> out_valid);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && mod_f != 2'd3) |=> !out_valid);

  // R9
  seg_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(used_regs[MASK_W-1:NUM_PTR]) == 1);

  // R9
  ptr_count_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(used_regs[NUM_PTR-1:0]) <= 2);

  // R8
  phys_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> phys_addr == PHYS_W'({seg_base, {SEG_SHIFT{1'b0}}} + SH_W'(ea_off)));

  // R7
  ovr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mod_f != 2'd3 && ovr_en) |=> seg_sel == $past(ovr_seg));
endmodule

// File: tb/test_real_ea_unit.sv
module test_real_ea_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] off;
    logic [1:0]  seg;
    logic [15:0] base;
    logic [19:0] phys;
    logic [7:0]  mask;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mod_f = '0;
  logic [2:0]  rm_f = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, disp = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic [15:0] seg_es = 16'h1000, seg_cs = 16'h2000, seg_ss = 16'h3000, seg_ds = 16'h4000;
  logic        out_valid;
  logic [15:0] ea_off, seg_base;
  logic [1:0]  seg_sel;
  logic [19:0] phys_addr;
  logic [7:0]  used_regs;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t  exp_q[$];
  string otag_q[$];
  string stag_q[$];
  string mtag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  real_ea_unit i_real_ea_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mod_f(mod_f), .rm_f(rm_f),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .disp(disp), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .out_valid(out_valid), .ea_off(ea_off), .seg_sel(seg_sel),
    .seg_base(seg_base), .phys_addr(phys_addr), .used_regs(used_regs)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic exp_t model(logic [1:0] m, logic [2:0] r, logic oe, logic [1:0] os);
    exp_t e;
    logic [15:0] d;
    logic [15:0] sv;
    bit stack;
    e.mask = '0;
    case (r)
      3'd0: begin e.off = reg_bx + reg_si; e.mask[0] = 1; e.mask[2] = 1; end
      3'd1: begin e.off = reg_bx + reg_di; e.mask[0] = 1; e.mask[3] = 1; end
      3'd2: begin e.off = reg_bp + reg_si; e.mask[1] = 1; e.mask[2] = 1; end
      3'd3: begin e.off = reg_bp + reg_di; e.mask[1] = 1; e.mask[3] = 1; end
      3'd4: begin e.off = reg_si; e.mask[2] = 1; end
      3'd5: begin e.off = reg_di; e.mask[3] = 1; end
      3'd6: begin
        if (m == 2'd0) e.off = 16'h0;
        else begin e.off = reg_bp; e.mask[1] = 1; end
      end
      default: begin e.off = reg_bx; e.mask[0] = 1; end
    endcase
    if (m == 2'd0) d = (r == 3'd6) ? disp : 16'h0;
    else if (m == 2'd1) d = {{8{disp[7]}}, disp[7:0]};
    else d = disp;
    e.off = e.off + d;
    stack = (r == 3'd2) || (r == 3'd3) || (r == 3'd6 && m != 2'd0);
    e.seg = oe ? os : (stack ? 2'd2 : 2'd3);
    case (e.seg)
      2'd0: sv = seg_es;
      2'd1: sv = seg_cs;
      2'd2: sv = seg_ss;
      default: sv = seg_ds;
    endcase
    e.base = sv;
    e.phys = {sv, 4'h0} + {4'h0, e.off};
    e.mask[4 + e.seg] = 1'b1;
    return e;
  endfunction

  task automatic drv(logic [1:0] m, logic [2:0] r, logic [15:0] d,
                     logic oe, logic [1:0] os, string otag);
    string t;
    @(negedge clk);
    mod_f = m; rm_f = r; disp = d; ovr_en = oe; ovr_seg = os; in_valid = 1'b1;
    if (m != 2'd3) begin
      if (otag != "") t = otag;
      else if (m == 2'd0 && r == 3'd6) t = "R2";
      else if (m == 2'd0) t = "R1";
      else if (m == 2'd1) t = "R3";
      else t = "R4";
      exp_q.push_back(model(m, r, oe, os));
      otag_q.push_back(t);
      stag_q.push_back(oe ? "R7" : "R6");
      mtag_q.push_back((m == 2'd0 && r == 3'd6) ? "R2" : "R9");
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: actual out_valid 1 expected 0");
      end else begin
        exp_t e;
        string to, ts, tm;
        e = exp_q.pop_front();
        to = otag_q.pop_front();
        ts = stag_q.pop_front();
        tm = mtag_q.pop_front();
        chk(to, 32'(ea_off), 32'(e.off));
        chk(ts, 32'(seg_sel), 32'(e.seg));
        chk(ts, 32'(seg_base), 32'(e.base));
        chk("R8", 32'(phys_addr), 32'(e.phys));
        chk(tm, 32'(used_regs), 32'(e.mask));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", 32'(out_valid), 0);
    chk("R11", 32'(ea_off), 0);
    chk("R11", 32'(phys_addr), 0);
    chk("R11", 32'(used_regs), 0);
    rst = 1'b0;
    reg_bx = 16'h0100; reg_bp = 16'h0220; reg_si = 16'h0033; reg_di = 16'h4004;

    // R1, R2, R6: mode 0 across all r/m codes
    for (int r = 0; r < 8; r++) drv(2'd0, 3'(r), 16'hABCD, 1'b0, 2'd0, "");
    // R3: negative and positive short displacements
    for (int r = 0; r < 8; r++) drv(2'd1, 3'(r), 16'h55F0, 1'b0, 2'd0, "");
    for (int r = 0; r < 8; r++) drv(2'd1, 3'(r), 16'hAA7F, 1'b0, 2'd0, "");
    // R4: full displacement
    for (int r = 0; r < 8; r++) drv(2'd2, 3'(r), 16'h1234, 1'b0, 2'd0, "");
    idle();

    // R10: single request appears exactly one cycle later
    drv(2'd2, 3'd7, 16'h0001, 1'b0, 2'd0, "");
    idle();
    chk("R10", 32'(out_valid), 1);
    @(negedge clk);
    chk("R10", 32'(out_valid), 0);

    // R10: register-direct mode yields nothing
    drv(2'd3, 3'd0, 16'h0000, 1'b0, 2'd0, "");
    idle();
    chk("R10", 32'(out_valid), 0);

    // R5: offset wrap
    @(negedge clk);
    reg_bx = 16'hFFFF; reg_si = 16'h0002; reg_bp = 16'hFFF0; reg_di = 16'hFF00;
    drv(2'd0, 3'd0, 16'h0000, 1'b0, 2'd0, "R5");
    drv(2'd2, 3'd3, 16'h0200, 1'b0, 2'd0, "R5");
    drv(2'd1, 3'd6, 16'h0080, 1'b0, 2'd0, "R5");
    idle();

    // R7: every override with a stack-default and a data-default form
    for (int s = 0; s < 4; s++) begin
      drv(2'd0, 3'd2, 16'h0000, 1'b1, 2'(s), "");
      drv(2'd1, 3'd7, 16'h0010, 1'b1, 2'(s), "");
    end
    idle();

    // R8: physical wrap past 20 bits
    @(negedge clk);
    seg_ds = 16'hFFFF; seg_ss = 16'hFFF8;
    reg_bx = 16'h0030; reg_bp = 16'h00A0;
    drv(2'd0, 3'd7, 16'h0000, 1'b0, 2'd0, "");
    drv(2'd2, 3'd6, 16'h0100, 1'b0, 2'd0, "");
    drv(2'd0, 3'd6, 16'hFFFF, 1'b0, 2'd0, "");
    idle();

    repeat (4) @(negedge clk);
    chk("R10", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule